// File: doc/BRIEF.md
# SRAM Access Pulse Sequencer

This block produces the control pulses for one access of a small register file built from SRAM cells. The file has 16 entries of 8 bits and supports two reads and one write in every system clock period. The block runs on a fast timing clock that is eight times the system clock. It samples the system clock as a level and measures each system period in eight timing slots. Slot 0 is the timing cycle in which the rising edge of the system clock is first seen. Slot 4 is the cycle in which the falling edge is seen.

Each period runs three phases in a fixed order. The read phase comes first: a read wordline enable and a column enable, then a sense-amplifier enable. The write phase follows: a write-driver enable that puts data on the bit lines, then a write wordline pulse that is gated by the write enable. Precharge is last and is driven through an active-low control. Every pulse output is registered, so each one appears one timing cycle after the slot that selects it.

The read addresses are captured on the rising system edge. The write enable, write address and write data are captured on the falling edge. The captured values are what the array's decoders and write drivers see.

Top module: `sram_pulse_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, `rd_wl_en`, `col_en`, `sae_en`, `wdrv_en` and `wr_wl_en` are 0 and `pch_n` is 0 (precharge active).
- R2: After reset is released, no enable goes high and `pch_n` stays 0 until the first rising edge of `sys_clk`, even if reset is released partway through a high phase.
- R3: `rd_wl_en` and `col_en` are 1 for the first and second timing cycles after the rising edge is seen, and 0 for the rest of the period.
- R4: `sae_en` is 1 only in the third timing cycle of the period, after the read wordline has fallen.
- R5: `wdrv_en` is 1 in the fourth, fifth and sixth timing cycles of the period.
- R6: `wr_wl_en` is 1 in the fifth and sixth timing cycles only when `we` is 1 at the falling edge of `sys_clk`. It is never 1 without `wdrv_en`.
- R7: `pch_n` is 0 in the seventh and eighth timing cycles and 1 in the first six. It is never 0 while a wordline or sense enable is 1.
- R8: `raddr_q` (port 0 in bits 3:0, port 1 in bits 7:4) takes `raddr` at the rising edge. It holds that value for the whole period, and later changes of `raddr` have no effect.
- R9: `waddr_q` and `wdata_q` take `waddr` and `wdata` at the falling edge and hold while `wr_wl_en` is 1. Later input changes have no effect.
- R10: An array driven by these pulses returns, on both read ports, the data written in earlier periods. A write to the same address in the same period is not visible to that period's reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, 8x the system clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_clk | input | 1 | System clock, sampled as a level |
| raddr | input | 8 | Read addresses, port 1 in the upper nibble |
| we | input | 1 | Write enable, taken at the falling edge |
| waddr | input | 4 | Write address |
| wdata | input | 8 | Write data |
| rd_wl_en | output | 1 | Read wordline enable |
| col_en | output | 1 | Column circuitry enable |
| sae_en | output | 1 | Sense-amplifier enable |
| wdrv_en | output | 1 | Write-driver (input buffer) enable |
| wr_wl_en | output | 1 | Write wordline enable |
| pch_n | output | 1 | Precharge control, active low |
| raddr_q | output | 8 | Captured read addresses |
| waddr_q | output | 4 | Captured write address |
| wdata_q | output | 8 | Captured write data |

## Verification
The assertions check on every cycle that the pulses do not conflict with each other:
- precharge is never active while a wordline or sense enable is active;
- the sense enable rises only just after the read wordline;
- the write wordline never fires without the driver;
- the captured addresses and data stay stable while their wordlines are high;
- nothing fires before the sequencer is armed.

Only the bench scenarios can show the exact slot of each pulse, the gating by the write enable, and the idle gap when reset is released mid-period. They also show that a behavioural array read through these pulses returns the right data, including a write and a read to the same address in one period.

// File: rtl/sps_pkg.sv
package sps_pkg;

  // True when a slot index falls inside the window [start, start+width)
  function automatic logic in_window(int slot, int start, int width);
    return (slot >= start) && (slot < start + width);
  endfunction

  // Next slot value; the count stops at the last slot until a new edge
  function automatic int next_slot(int slot, int last);
    return (slot >= last) ? last : slot + 1;
  endfunction

  // Gate value for the write wordline: the fresh input at the falling edge,
  // otherwise the value captured at that edge
  function automatic logic wr_gate(logic fall, logic we_in, logic we_held);
    return fall ? we_in : we_held;
  endfunction

endpackage

// File: rtl/sps_phase.sv
module sps_phase #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_clk,
  output logic          sys_rise,
  output logic          sys_fall,
  output logic          seq_active,
  output logic          armed,
  output logic [SW-1:0] slot
);
  import sps_pkg::*;

  localparam int LAST = SLOTS - 1;

  logic          sys_q;
  logic [SW-1:0] slot_q;

  assign sys_rise   = sys_clk & ~sys_q;
  assign sys_fall   = ~sys_clk & sys_q;
  assign slot       = sys_rise ? '0 : slot_q;
  assign seq_active = armed | sys_rise;

  // The edge detector is left out of reset on purpose: a level seen at
  // release must not look like a fresh edge.
  always_ff @(posedge clk) sys_q <= sys_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SW'(LAST);
      armed  <= 1'b0;
    end else begin
      slot_q <= SW'(next_slot(int'(slot), LAST));
      armed  <= seq_active;
    end
  end

endmodule

// File: rtl/sps_pulse.sv
module sps_pulse #(
  parameter int   SW      = 3,
  parameter int   START   = 0,
  parameter int   WIDTH   = 1,
  parameter logic IDLE    = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          gate,
  input  logic [SW-1:0] slot,
  output logic          pulse
);
  import sps_pkg::*;

  logic hit;
  assign hit = in_window(int'(slot), START, WIDTH) & gate;

  always_ff @(posedge clk) begin
    if (rst)          pulse <= IDLE;
    else if (!active) pulse <= IDLE;
    else              pulse <= hit;
  end

endmodule

// File: rtl/sps_capture.sv
module sps_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sram_pulse_seq.sv
module sram_pulse_seq #(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int NRD        = 2,
  parameter int SLOTS      = 8,
  parameter int RWL_START  = 0,
  parameter int RWL_W      = 2,
  parameter int SAE_START  = 2,
  parameter int SAE_W      = 1,
  parameter int WDRV_START = 3,
  parameter int WDRV_W     = 3,
  parameter int WWL_START  = 4,
  parameter int WWL_W      = 2,
  parameter int PCH_START  = 6,
  parameter int PCH_W      = 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_clk,
  input  logic [NRD*AW-1:0] raddr,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  output logic              rd_wl_en,
  output logic              col_en,
  output logic              sae_en,
  output logic              wdrv_en,
  output logic              wr_wl_en,
  output logic              pch_n,
  output logic [NRD*AW-1:0] raddr_q,
  output logic [AW-1:0]     waddr_q,
  output logic [DW-1:0]     wdata_q
);
  import sps_pkg::*;

  // Named internal events, visible to the bound checker
  logic          sys_rise, sys_fall, seq_active, seq_armed;
  logic [SW-1:0] cur_slot;
  logic          we_q, wwl_gate, pch_pulse;

  sps_phase #(.SLOTS(SLOTS)) u_phase (
    .clk(clk), .rst(rst), .sys_clk(sys_clk),
    .sys_rise(sys_rise), .sys_fall(sys_fall),
    .seq_active(seq_active), .armed(seq_armed), .slot(cur_slot)
  );

  // Read addresses: one capture register per read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    sps_capture #(.W(AW)) u_cap (
      .clk(clk), .rst(rst), .load(sys_rise),
      .d(raddr[p*AW +: AW]), .q(raddr_q[p*AW +: AW])
    );
  end

  sps_capture #(.W(1 + AW + DW)) u_wcap (
    .clk(clk), .rst(rst), .load(sys_fall),
    .d({we, waddr, wdata}), .q({we_q, waddr_q, wdata_q})
  );

  assign wwl_gate = wr_gate(sys_fall, we, we_q);

  sps_pulse #(.SW(SW), .START(RWL_START), .WIDTH(RWL_W), .IDLE(1'b0)) u_rwl (
    .clk(clk), .rst(rst), .active(seq_active), .gate(1'b1),
    .slot(cur_slot), .pulse(rd_wl_en)
  );

  sps_pulse #(.SW(SW), .START(SAE_START), .WIDTH(SAE_W), .IDLE(1'b0)) u_sae (
    .clk(clk), .rst(rst), .active(seq_active), .gate(1'b1),
    .slot(cur_slot), .pulse(sae_en)
  );

  sps_pulse #(.SW(SW), .START(WDRV_START), .WIDTH(WDRV_W), .IDLE(1'b0)) u_wdrv (
    .clk(clk), .rst(rst), .active(seq_active), .gate(1'b1),
    .slot(cur_slot), .pulse(wdrv_en)
  );

  sps_pulse #(.SW(SW), .START(WWL_START), .WIDTH(WWL_W), .IDLE(1'b0)) u_wwl (
    .clk(clk), .rst(rst), .active(seq_active), .gate(wwl_gate),
    .slot(cur_slot), .pulse(wr_wl_en)
  );

  // Precharge idles active (pulse high) so the bit lines sit charged
  sps_pulse #(.SW(SW), .START(PCH_START), .WIDTH(PCH_W), .IDLE(1'b1)) u_pch (
    .clk(clk), .rst(rst), .active(seq_active), .gate(1'b1),
    .slot(cur_slot), .pulse(pch_pulse)
  );

  assign pch_n  = ~pch_pulse;
  assign col_en = rd_wl_en;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int NRD = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              seq_armed,
  input logic              rd_wl_en,
  input logic              sae_en,
  input logic              wdrv_en,
  input logic              wr_wl_en,
  input logic              pch_n,
  input logic [NRD*AW-1:0] raddr_q,
  input logic [AW-1:0]     waddr_q,
  input logic [DW-1:0]     wdata_q
);

  p_idle_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
    !seq_armed |-> (!rd_wl_en && !sae_en && !wdrv_en && !wr_wl_en && !pch_n));

  p_sae_after_wl_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sae_en) |-> (!rd_wl_en && $past(rd_wl_en)));

  p_wwl_needs_drv_r6: assert property (@(posedge clk) disable iff (rst)
    wr_wl_en |-> wdrv_en);

  p_pch_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !pch_n |-> !(rd_wl_en || sae_en || wr_wl_en));

  p_raddr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_wl_en && $past(rd_wl_en)) |-> $stable(raddr_q));

  p_wside_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_wl_en && $past(wr_wl_en)) |-> ($stable(waddr_q) && $stable(wdata_q)));

endmodule

bind sram_pulse_seq sps_checker #(.AW(AW), .DW(DW), .NRD(NRD)) u_chk (
  .clk(clk), .rst(rst), .seq_armed(seq_armed),
  .rd_wl_en(rd_wl_en), .sae_en(sae_en), .wdrv_en(wdrv_en),
  .wr_wl_en(wr_wl_en), .pch_n(pch_n),
  .raddr_q(raddr_q), .waddr_q(waddr_q), .wdata_q(wdata_q)
);

// File: tb/tb_sram_pulse_seq.sv
module tb_sram_pulse_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, sys_clk, we;
  logic [7:0] raddr, wdata;
  logic [3:0] waddr;
  logic       rd_wl_en, col_en, sae_en, wdrv_en, wr_wl_en, pch_n;
  logic [7:0] raddr_q, wdata_q;
  logic [3:0] waddr_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pulse_seq dut (
    .clk(clk), .rst(rst), .sys_clk(sys_clk), .raddr(raddr), .we(we),
    .waddr(waddr), .wdata(wdata), .rd_wl_en(rd_wl_en), .col_en(col_en),
    .sae_en(sae_en), .wdrv_en(wdrv_en), .wr_wl_en(wr_wl_en), .pch_n(pch_n),
    .raddr_q(raddr_q), .waddr_q(waddr_q), .wdata_q(wdata_q)
  );

  typedef struct {
    logic [3:0] a0, a1, wa;
    logic [7:0] d0, d1, wd;
    logic       w;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] shadow [16];  // expectation, updated by the driver
  logic [7:0] arr    [16];  // behavioural array, driven by the pulses

  task automatic chk(string req, logic ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: one full system period, pushing its expected item first
  task automatic sys_cycle(logic [3:0] a0, logic [3:0] a1, logic w,
                           logic [3:0] wa, logic [7:0] wd);
    item_t it;
    it.a0 = a0; it.a1 = a1; it.d0 = shadow[a0]; it.d1 = shadow[a1];
    it.w = w; it.wa = wa; it.wd = wd;
    exp_q.push_back(it);
    if (w) shadow[wa] = wd;
    sys_clk = 1'b1;
    raddr = {a1, a0};
    @(negedge clk);
    raddr = ~{a1, a0};               // later changes must be ignored (R8)
    repeat (3) @(negedge clk);
    sys_clk = 1'b0;
    we = w; waddr = wa; wdata = wd;
    @(negedge clk);
    we = ~w; waddr = ~wa; wdata = ~wd; // ignored after capture (R9)
    repeat (3) @(negedge clk);
  endtask

  // Monitor: locates each slot from the sys_clk it sees, models the array
  initial begin
    int    j = 8;
    logic  prev_sys = 1'b0;
    logic  seen = 1'b0;
    logic  idle_bad = 1'b0;
    logic  e_rwl, e_sae, e_drv, e_wwl, e_pch;
    item_t cur;
    cur = '{default: '0};
    e_rwl = 0; e_sae = 0; e_drv = 0; e_wwl = 0; e_pch = 0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst) begin
        seen = 1'b0;
        idle_bad = 1'b0;
      end else begin
        if (sys_clk && !prev_sys) begin
          if (!seen)
            chk("R2", !idle_bad, "output active before first rising edge", idle_bad, 0);
          seen = 1'b1;
          j = 0;
          e_rwl = 0; e_sae = 0; e_drv = 0; e_wwl = 0; e_pch = 0;
        end else if (j < 8) begin
          j++;
        end
        if (!seen) begin
          if (rd_wl_en || col_en || sae_en || wdrv_en || wr_wl_en || pch_n)
            idle_bad = 1'b1;
        end else if (j < 8) begin
          if (wr_wl_en && wdrv_en) arr[waddr_q] = wdata_q;
          if (j == 0) begin
            if (exp_q.size() == 0) begin
              chk("R10", 1'b0, "expected queue empty", 0, 1);
            end else begin
              cur = exp_q.pop_front();
              chk("R8", raddr_q == {cur.a1, cur.a0}, "raddr_q at rise", raddr_q, {cur.a1, cur.a0});
            end
          end
          if (j == 2) begin
            chk("R8", raddr_q == {cur.a1, cur.a0}, "raddr_q held at sense", raddr_q, {cur.a1, cur.a0});
            chk("R10", arr[raddr_q[3:0]] == cur.d0, "read port 0 data", arr[raddr_q[3:0]], cur.d0);
            chk("R10", arr[raddr_q[7:4]] == cur.d1, "read port 1 data", arr[raddr_q[7:4]], cur.d1);
          end
          if (j == 5) begin
            chk("R9", waddr_q == cur.wa, "waddr_q held", waddr_q, cur.wa);
            chk("R9", wdata_q == cur.wd, "wdata_q held", wdata_q, cur.wd);
          end
          if (rd_wl_en != (j < 2) || col_en != (j < 2)) e_rwl = 1;
          if (sae_en != (j == 2)) e_sae = 1;
          if (wdrv_en != (j >= 3 && j <= 5)) e_drv = 1;
          if (wr_wl_en != (cur.w && (j == 4 || j == 5))) e_wwl = 1;
          if (pch_n != (j < 6)) e_pch = 1;
          if (j == 7) begin
            chk("R3", !e_rwl, "read wordline/column slots", e_rwl, 0);
            chk("R4", !e_sae, "sense enable slot", e_sae, 0);
            chk("R5", !e_drv, "write driver slots", e_drv, 0);
            chk("R6", !e_wwl, "write wordline slots", e_wwl, 0);
            chk("R7", !e_pch, "precharge slots", e_pch, 0);
          end
        end
      end
      prev_sys = sys_clk;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk("WATCHDOG", 1'b0, "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 8'h00;
      arr[i]    = 8'h00;
    end
    rst = 1'b1; sys_clk = 1'b0; we = 1'b0;
    raddr = '0; waddr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", !(rd_wl_en || col_en || sae_en || wdrv_en || wr_wl_en),
        "enables in reset", {rd_wl_en, sae_en, wdrv_en, wr_wl_en}, 0);
    chk("R1", pch_n == 1'b0, "pch_n in reset", pch_n, 0);
    // Release reset partway through a high phase of sys_clk
    sys_clk = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    sys_clk = 1'b0;
    repeat (4) @(negedge clk);

    sys_cycle(4'h0, 4'hF, 1'b1, 4'h3, 8'hA5);
    sys_cycle(4'h3, 4'h3, 1'b1, 4'hF, 8'h5A);
    sys_cycle(4'hF, 4'h3, 1'b0, 4'h3, 8'hFF);  // no write: entry 3 keeps A5
    sys_cycle(4'h3, 4'h0, 1'b1, 4'h0, 8'h81);
    sys_cycle(4'h0, 4'h0, 1'b1, 4'h0, 8'h7E);  // read and write same entry
    sys_cycle(4'h0, 4'hF, 1'b0, 4'hF, 8'h00);
    sys_cycle(4'h7, 4'h8, 1'b1, 4'h7, 8'h3C);
    sys_cycle(4'h7, 4'h8, 1'b1, 4'h8, 8'hC3);
    sys_cycle(4'h8, 4'h7, 1'b0, 4'h8, 8'h11);
    sys_cycle(4'h3, 4'hF, 1'b0, 4'h0, 8'h00);

    repeat (10) @(negedge clk);
    chk("R10", exp_q.size() == 0, "items left in queue", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule